// File: doc/BRIEF.md
# Dual-Structure Serial CRC-5 Generator

This block forms a 5-bit cyclic redundancy check over a serial bit stream that arrives most significant bit first. The generator polynomial is x^5 + x^2 + x + 1, written as the coefficient pattern 100111. A `start` pulse clears the remainder register to zero. Each data bit is then offered on `bit_in` together with `bit_vld`. The last bit of the message is marked by holding `msg_end` high in the same cycle as its `bit_vld`.

The structure is chosen per message through `mode_aug`, which is sampled in the `start` cycle. The direct structure (`mode_aug` = 0) folds each incoming bit into the feedback term, so the remainder is final once the last data bit has been taken. The augmented structure (`mode_aug` = 1) works like long division. Each data bit enters the low end of the register. After the message the block feeds in five zero bits of its own, which multiplies the message by x^5 before the remainder is taken. For the same message both structures give the same remainder. They differ only in how long they stay busy.

The controller has four states. IDLE is the rest state after reset. TAKE accepts data bits. FLUSH performs the five self-generated zero shifts, in augmented mode only. FIN raises `done` for a single cycle. The transitions are as follows:
- start: any state goes to TAKE when `start` is high.
- last-direct: TAKE goes to FIN when the last bit is taken in direct mode.
- last-augmented: TAKE goes to FLUSH when the last bit is taken in augmented mode.
- flush-over: FLUSH goes to FIN after the fifth zero shift.
- retire: FIN goes to IDLE unconditionally.

Top module: `crc5_serial_gen`

## Requirements
- R1: After reset `busy` = 0, `done` = 0 and `crc` = 00000.
- R2: A `start` pulse clears `crc` to 00000 in the next cycle and raises `busy`. This holds in either mode and from any state.
- R3: In direct mode each accepted bit D turns {c4,c3,c2,c1,c0} into {c3, c2, c1^c4^D, c0^c4^D, c4^D}. The message 1 gives 00111, the message 10010011 gives 01010, and the message 100111 gives 00000.
- R4: In direct mode `done` is high in the cycle right after the cycle in which the last bit is taken. `busy` is low from that cycle on.
- R5: In augmented mode each shift turns the register into {c3, c2, c1^c4, c0^c4, D^c4}. After the last data bit the block makes exactly five shifts with D = 0, and `done` is high six cycles after the last-bit cycle. The message 10010011 gives 01010 in this mode as well.
- R6: During the five flush shifts `busy` stays high and `bit_in`, `bit_vld` and `msg_end` have no effect on the result.
- R7: A bit is taken only in a cycle where `bit_vld` is high. Cycles with `bit_vld` low leave the remainder unchanged, whatever `bit_in` holds.
- R8: `done` lasts exactly one cycle. After it, `crc` holds its value until the next `start`, whatever the data inputs do.
- R9: For any message of 1 to 64 bits, both modes return (M(x)·x^5) mod G(x).
- R10: The mode is captured at `start`. A change of `mode_aug` during a message does not change the result or the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the remainder and begins a message |
| mode_aug | input | 1 | 0 = direct structure, 1 = augmented structure; sampled at start |
| bit_in | input | 1 | Serial data bit, most significant first |
| bit_vld | input | 1 | Qualifies bit_in |
| msg_end | input | 1 | Marks the bit taken in this cycle as the last one |
| busy | output | 1 | High in TAKE and FLUSH |
| done | output | 1 | One-cycle pulse after the final shift |
| crc | output | 5 | Remainder register, bit 4 = c4 |

## Verification
The assertions watch the control timing on every cycle. A start always clears the register and raises busy. In direct mode, done follows the last bit in the next cycle. In augmented mode, exactly five cycles pass between the last-bit cycle and done. Done never overlaps busy and never lasts two cycles, and the remainder is frozen whenever the block is idle. The arithmetic itself can only be shown by the bench's scenarios, because they compare the final remainder with an independent polynomial division. These scenarios cover a fixed set of known messages, random lengths up to 64 bits with idle gaps, junk data driven during the flush, and a mode input that changes in the middle of a message.

// File: rtl/crc5_pkg.sv
package crc5_pkg;

    // Register width and the low terms of x^5 + x^2 + x + 1
    localparam int          CRC_W    = 5;
    localparam logic [4:0]  POLY_LOW = 5'b00111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TAKE  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_FIN   = 2'd3
    } crc_state_e;

endpackage

// File: rtl/crc5_shift_core.sv
module crc5_shift_core #(
    parameter int               W    = crc5_pkg::CRC_W,
    parameter logic [W-1:0]     POLY = crc5_pkg::POLY_LOW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         aug,
    input  logic         din,
    output logic [W-1:0] rem_o
);

    logic [W-1:0] rem_q;
    logic [W-1:0] rem_nxt;
    logic         fb;
    logic         lo_in;

    // Direct: data joins the feedback term. Augmented: data enters low end.
    assign fb    = aug ? rem_q[W-1] : (rem_q[W-1] ^ din);
    assign lo_in = aug ? din : 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign rem_nxt[0] = lo_in ^ (POLY[0] & fb);
        end else begin : g_hi
            assign rem_nxt[i] = rem_q[i-1] ^ (POLY[i] & fb);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (clr) begin
            rem_q <= '0;
        end else if (shift_en) begin
            rem_q <= rem_nxt;
        end
    end

    assign rem_o = rem_q;

endmodule

// File: rtl/crc5_flush_cnt.sv
module crc5_flush_cnt #(
    parameter int W = crc5_pkg::CRC_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_clr,
    input  logic cnt_en,
    output logic last_o
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_clr) begin
            cnt_q <= '0;
        end else if (cnt_en) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last_o = (cnt_q == CW'(W - 1));

endmodule

// File: rtl/crc5_seq_ctrl.sv
module crc5_seq_ctrl
    import crc5_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mode_in,
    input  logic       bit_vld,
    input  logic       msg_end,
    input  logic       flush_last,
    output crc_state_e state_o,
    output logic       mode_q,
    output logic       reg_clr,
    output logic       shift_en,
    output logic       zero_in,
    output logic       cnt_clr,
    output logic       cnt_en,
    output logic       busy,
    output logic       done
);

    crc_state_e state_q;
    crc_state_e state_d;

    // State register and captured mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                mode_q <= mode_in;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_TAKE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_TAKE:  if (bit_vld && msg_end) state_d = mode_q ? ST_FLUSH : ST_FIN;
                ST_FLUSH: if (flush_last) state_d = ST_FIN;
                ST_FIN:   state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        reg_clr  = start;
        shift_en = 1'b0;
        zero_in  = 1'b0;
        cnt_clr  = 1'b0;
        cnt_en   = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_TAKE: begin
                busy     = 1'b1;
                shift_en = bit_vld && !start;
                cnt_clr  = 1'b1;
            end
            ST_FLUSH: begin
                busy     = 1'b1;
                zero_in  = 1'b1;
                shift_en = !start;
                cnt_en   = !start;
            end
            ST_FIN: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/crc5_serial_gen.sv
module crc5_serial_gen
    import crc5_pkg::*;
#(
    parameter int           W    = CRC_W,
    parameter logic [W-1:0] POLY = POLY_LOW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         mode_aug,
    input  logic         bit_in,
    input  logic         bit_vld,
    input  logic         msg_end,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] crc
);

    crc_state_e state_q;
    logic       mode_q;
    logic       reg_clr;
    logic       shift_en;
    logic       zero_in;
    logic       cnt_clr;
    logic       cnt_en;
    logic       flush_last;
    logic       din;

    crc5_seq_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_in    (mode_aug),
        .bit_vld    (bit_vld),
        .msg_end    (msg_end),
        .flush_last (flush_last),
        .state_o    (state_q),
        .mode_q     (mode_q),
        .reg_clr    (reg_clr),
        .shift_en   (shift_en),
        .zero_in    (zero_in),
        .cnt_clr    (cnt_clr),
        .cnt_en     (cnt_en),
        .busy       (busy),
        .done       (done)
    );

    crc5_flush_cnt #(.W(W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_clr (cnt_clr),
        .cnt_en  (cnt_en),
        .last_o  (flush_last)
    );

    assign din = zero_in ? 1'b0 : bit_in;

    crc5_shift_core #(.W(W), .POLY(POLY)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (reg_clr),
        .shift_en (shift_en),
        .aug      (mode_q),
        .din      (din),
        .rem_o    (crc)
    );

endmodule

// File: rtl/crc5_serial_gen_chk.sv
module crc5_serial_gen_chk
    import crc5_pkg::*;
#(
    parameter int W = CRC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         bit_vld,
    input logic         msg_end,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] crc,
    input logic         mode_q,
    input crc_state_e   state_q
);

    logic       trk_q;
    logic [7:0] gap_q;
    logic       aug_last;

    assign aug_last = !start && (state_q == ST_TAKE) && mode_q && bit_vld && msg_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= 1'b0;
            gap_q <= '0;
        end else if (start) begin
            trk_q <= 1'b0;
            gap_q <= '0;
        end else if (aug_last) begin
            trk_q <= 1'b1;
            gap_q <= '0;
        end else if (trk_q && done) begin
            trk_q <= 1'b0;
        end else if (trk_q) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (crc == '0) && busy);

    // R4
    direct_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && busy && !mode_q && bit_vld && msg_end) |=> (done && !busy));

    // R5
    flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q && done) |-> (gap_q == 8'(W)));

    // R6
    flush_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q && !done) |-> busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(crc));

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

endmodule

bind crc5_serial_gen crc5_serial_gen_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .bit_vld (bit_vld),
    .msg_end (msg_end),
    .busy    (busy),
    .done    (done),
    .crc     (crc),
    .mode_q  (mode_q),
    .state_q (state_q)
);

// File: tb/crc5_serial_gen_tb_top.sv
module crc5_serial_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode_aug = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic       msg_end = 1'b0;
    logic       busy;
    logic       done;
    logic [4:0] crc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    crc5_serial_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_aug (mode_aug),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .msg_end  (msg_end),
        .busy     (busy),
        .done     (done),
        .crc      (crc)
    );

    typedef struct packed {
        logic [6:0]  len;
        logic [63:0] msg;
        logic        aug;
        logic [4:0]  exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{7'd8, 64'h93, 1'b0, 5'b01010},
        '{7'd8, 64'h93, 1'b1, 5'b01010},
        '{7'd1, 64'h1,  1'b0, 5'b00111},
        '{7'd1, 64'h1,  1'b1, 5'b00111},
        '{7'd1, 64'h0,  1'b0, 5'b00000},
        '{7'd1, 64'h0,  1'b1, 5'b00000},
        '{7'd6, 64'h27, 1'b0, 5'b00000},
        '{7'd6, 64'h27, 1'b1, 5'b00000}
    };

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Long division of M(x)*x^5 by 100111
    function automatic logic [4:0] ref_crc(int len, logic [63:0] msg);
        logic [68:0] v;
        v = 69'(msg) << 5;
        for (int i = len + 4; i >= 5; i--) begin
            if (v[i]) v[i -: 6] = v[i -: 6] ^ 6'b100111;
        end
        return v[4:0];
    endfunction

    // Sends one message; returns final crc and cycles from last bit to done
    task automatic run_msg(input logic aug, input int len, input logic [63:0] msg,
                           input bit gaps, input bit junk, input bit flip_mode,
                           output logic [4:0] res, output int lat);
        @(negedge clk);
        start = 1'b1; mode_aug = aug; bit_vld = 1'b0; msg_end = 1'b0;
        @(negedge clk);
        start = 1'b0;
        if (flip_mode) mode_aug = ~aug;
        check("R2", "crc cleared", 32'(crc), 32'h0);
        check("R2", "busy after start", 32'(busy), 32'h1);
        for (int k = 0; k < len; k++) begin
            if (gaps) begin
                for (int g = 0; g < int'($urandom % 3); g++) begin
                    bit_vld = 1'b0; bit_in = 1'($urandom); msg_end = 1'($urandom);
                    @(negedge clk);
                end
            end
            bit_vld = 1'b1;
            bit_in  = msg[len-1-k];
            msg_end = (k == len - 1);
            @(negedge clk);
        end
        lat = 0;
        res = 5'h1f;
        for (int w = 0; w < 20; w++) begin
            bit_vld = junk ? 1'($urandom) : 1'b0;
            bit_in  = 1'($urandom);
            msg_end = junk ? 1'($urandom) : 1'b0;
            lat++;
            if (done) begin
                res = crc;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_hold(string req, logic [4:0] val);
        for (int h = 0; h < 3; h++) begin
            bit_vld = 1'($urandom); bit_in = 1'($urandom); msg_end = 1'($urandom);
            @(negedge clk);
            check(req, "done low after pulse", 32'(done), 32'h0);
            check(req, "crc held", 32'(crc), 32'(val));
        end
        bit_vld = 1'b0; msg_end = 1'b0;
    endtask

    initial begin
        logic [4:0]  r;
        int          lat;
        logic [63:0] m;
        int          len;
        logic        a;

        repeat (3) @(negedge clk);
        check("R1", "busy at reset", 32'(busy), 32'h0);
        check("R1", "done at reset", 32'(done), 32'h0);
        check("R1", "crc at reset", 32'(crc), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "crc after reset", 32'(crc), 32'h0);

        // Table of known messages
        for (int v = 0; v < NV; v++) begin
            run_msg(VECS[v].aug, int'(VECS[v].len), VECS[v].msg, 1'b0, 1'b0, 1'b0, r, lat);
            check(VECS[v].aug ? "R5" : "R3", "table crc", 32'(r), 32'(VECS[v].exp));
            check(VECS[v].aug ? "R5" : "R4", "table latency", 32'(lat), VECS[v].aug ? 32'd6 : 32'd1);
        end

        // Hold after done
        run_msg(1'b1, 8, 64'h93, 1'b0, 1'b0, 1'b0, r, lat);
        check_hold("R8", r);

        // Junk during flush
        run_msg(1'b1, 8, 64'h93, 1'b0, 1'b1, 1'b0, r, lat);
        check("R6", "crc with junk in flush", 32'(r), 32'h0a);
        check("R6", "latency with junk", 32'(lat), 32'd6);

        // Gaps with bit_vld low
        run_msg(1'b0, 8, 64'h93, 1'b1, 1'b0, 1'b0, r, lat);
        check("R7", "direct crc with gaps", 32'(r), 32'h0a);

        // Mode changed mid message
        run_msg(1'b0, 8, 64'h93, 1'b0, 1'b0, 1'b1, r, lat);
        check("R10", "direct kept", 32'(lat), 32'd1);
        run_msg(1'b1, 8, 64'h93, 1'b0, 1'b0, 1'b1, r, lat);
        check("R10", "augmented kept", 32'(lat), 32'd6);
        check("R10", "augmented crc", 32'(r), 32'h0a);

        // Restart in the middle of a message
        @(negedge clk);
        start = 1'b1; mode_aug = 1'b0;
        @(negedge clk);
        start = 1'b0; bit_vld = 1'b1; bit_in = 1'b1; msg_end = 1'b0;
        @(negedge clk);
        bit_vld = 1'b0;
        run_msg(1'b0, 1, 64'h1, 1'b0, 1'b0, 1'b0, r, lat);
        check("R2", "crc after restart", 32'(r), 32'h07);

        // Random messages, both modes
        for (int t = 0; t < 60; t++) begin
            len = 1 + int'($urandom % 64);
            m   = {$urandom, $urandom};
            if (len < 64) m = m & ((64'h1 << len) - 64'h1);
            a   = 1'(t);
            run_msg(a, len, m, 1'b1, 1'b1, 1'($urandom), r, lat);
            check("R9", "random crc", 32'(r), 32'(ref_crc(len, m)));
            check(a ? "R5" : "R4", "random latency", 32'(lat), a ? 32'd6 : 32'd1);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule